// File: doc/BRIEF.md
# Local Exclusive-Access Reservation Monitor

This block sits beside one processor core and watches the memory requests that the core issues. An exclusive load opens a reservation on the granule that holds its physical address. A later exclusive store to the same granule is allowed to reach memory only while that reservation is still held. The block gives each exclusive store a verdict in the same cycle: a permit strobe that gates the memory write, and a 32-bit status word that goes back to the core's destination register.

The block holds a single reservation, which is a granule-aligned address plus a valid flag. Any exclusive store, a clear-exclusive request or an exception return drops the reservation. Ordinary loads and stores leave it unchanged. The granule size is a build-time power of two, and addresses are compared with the offset bits inside a granule ignored. An exclusive access whose address is not a multiple of its size never holds a reservation.

Top module: `excl_monitor`

## Requirements
- R1: When `req_valid_i` is high and `req_op_i` is 2 (exclusive load) with an aligned address, the monitor becomes tagged with the granule that holds `req_addr_i`, starting from the next cycle.
- R2: Only one reservation is held at a time. A new exclusive load replaces any earlier one, so a later exclusive store to the old granule fails.
- R3: `st_permit_o` is high, in the same cycle as the request, only for an exclusive store (`req_op_i` = 3) that is aligned and whose address lies in the tagged granule. In every other case the store is suppressed.
- R4: For an exclusive store, `status_o` is 32'd0 when it passes and 32'd1 when it fails. When no exclusive store is presented, `status_o` is 0 and `st_permit_o` is low.
- R5: Every exclusive store clears the tag from the next cycle, whether it passes or fails.
- R6: A clear-exclusive request (`req_op_i` = 4) clears the tag.
- R7: An exception return (`req_op_i` = 5) clears the tag.
- R8: Addresses are compared at the resolution of a granule of `GRANULE_B` bytes (a power of two, 64 by default). Any two addresses that differ only in their low log2(`GRANULE_B`) bits match.
- R9: `req_size_i` encodes the access size as 0 for a byte, 1 for a halfword, 2 for a word and 3 for a doubleword. An exclusive store whose address is not a multiple of its size fails. An exclusive load whose address is not a multiple of its size leaves the monitor untagged.
- R10: Ordinary loads (`req_op_i` = 0), ordinary stores (1) and the unused codes 6 and 7 leave the reservation unchanged.
- R11: After reset the monitor is untagged, so the first exclusive store fails.
- R12: When `req_valid_i` is low, the reservation is unchanged and both outputs are inactive, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe from the core |
| req_op_i | input | 3 | Request kind: 0 load, 1 store, 2 exclusive load, 3 exclusive store, 4 clear-exclusive, 5 exception return |
| req_addr_i | input | PA_W | Physical address of the request |
| req_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| st_permit_o | output | 1 | Exclusive store may write memory (same cycle) |
| status_o | output | 32 | Exclusive-store result: 0 pass, 1 fail |

## Verification
On every cycle, the assertions check how the reservation state follows the request stream. They check that each clearing request empties the tag, that a byte-sized exclusive load records its granule, that ordinary traffic and idle cycles leave the state as it was, and that a permit only goes out against a valid matching tag with a consistent status word. The bench scenarios are needed to show the request sequences that play out over several cycles. These are replacement of an older reservation, granule aliasing between neighbouring addresses, the alignment rules for each access size, and the pass-then-fail pattern of two back-to-back exclusive stores.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  localparam int unsigned STAT_W = 32;
  localparam logic [STAT_W-1:0] STAT_PASS = '0;
  localparam logic [STAT_W-1:0] STAT_FAIL = STAT_W'(1);

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_LDEX  = 3'd2,
    OP_STEX  = 3'd3,
    OP_CLREX = 3'd4,
    OP_ERET  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } excl_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } excl_size_e;
endpackage

// File: rtl/excl_granule_match.sv
module excl_granule_match #(
  parameter int unsigned PA_W  = 40,
  parameter int unsigned G_LSB = 6
) (
  input  logic [PA_W-1:0] addr_i,
  input  logic [PA_W-1:0] tag_i,
  input  logic            tag_vld_i,
  output logic [PA_W-1:0] gran_o,
  output logic            hit_o
);
  localparam logic [PA_W-1:0] OFS_MASK = PA_W'((64'd1 << G_LSB) - 64'd1);

  assign gran_o = addr_i & ~OFS_MASK;
  assign hit_o  = tag_vld_i && (gran_o == tag_i);
endmodule

// File: rtl/excl_align_chk.sv
module excl_align_chk
  import excl_mon_pkg::*;
(
  input  logic [2:0]  low_addr_i,
  input  excl_size_e  size_i,
  output logic        aligned_o
);
  always_comb begin
    unique case (size_i)
      SZ_B:    aligned_o = 1'b1;
      SZ_H:    aligned_o = (low_addr_i[0] == 1'b0);
      SZ_W:    aligned_o = (low_addr_i[1:0] == 2'b00);
      default: aligned_o = (low_addr_i[2:0] == 3'b000);
    endcase
  end
endmodule

// File: rtl/excl_resv_reg.sv
module excl_resv_reg
  import excl_mon_pkg::*;
#(
  parameter int unsigned PA_W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  excl_op_e        op_i,
  input  logic            aligned_i,
  input  logic [PA_W-1:0] gran_i,
  output logic            vld_o,
  output logic [PA_W-1:0] tag_o
);
  logic            vld_d;
  logic [PA_W-1:0] tag_d;

  always_comb begin
    vld_d = vld_o;
    tag_d = tag_o;
    if (req_valid_i) begin
      unique case (op_i)
        OP_LDEX: begin
          vld_d = aligned_i;
          if (aligned_i) tag_d = gran_i;
        end
        OP_STEX, OP_CLREX, OP_ERET: vld_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
    end else begin
      vld_o <= vld_d;
      tag_o <= tag_d;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int unsigned PA_W      = 40,
  parameter int unsigned GRANULE_B = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [PA_W-1:0]   req_addr_i,
  input  logic [1:0]        req_size_i,
  output logic              st_permit_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned G_LSB = $clog2(GRANULE_B);

  excl_op_e        op;
  logic            aligned;
  logic            hit;
  logic            resv_vld;
  logic [PA_W-1:0] resv_tag;
  logic [PA_W-1:0] gran;
  logic            is_stex;

  assign op      = excl_op_e'(req_op_i);
  assign is_stex = req_valid_i && (op == OP_STEX);

  excl_align_chk i_align (
    .low_addr_i (req_addr_i[2:0]),
    .size_i     (excl_size_e'(req_size_i)),
    .aligned_o  (aligned)
  );

  excl_granule_match #(.PA_W(PA_W), .G_LSB(G_LSB)) i_match (
    .addr_i    (req_addr_i),
    .tag_i     (resv_tag),
    .tag_vld_i (resv_vld),
    .gran_o    (gran),
    .hit_o     (hit)
  );

  excl_resv_reg #(.PA_W(PA_W)) i_resv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .op_i        (op),
    .aligned_i   (aligned),
    .gran_i      (gran),
    .vld_o       (resv_vld),
    .tag_o       (resv_tag)
  );

  assign st_permit_o = is_stex && hit && aligned;
  assign status_o    = (is_stex && !st_permit_o) ? STAT_FAIL : STAT_PASS;
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int unsigned PA_W  = 40,
  parameter int unsigned G_LSB = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [2:0]      req_op_i,
  input logic [PA_W-1:0] req_addr_i,
  input logic [1:0]      req_size_i,
  input logic            st_permit_o,
  input logic [31:0]     status_o,
  input logic            resv_vld,
  input logic [PA_W-1:0] resv_tag
);
  localparam logic [PA_W-1:0] KEEP = ~PA_W'((64'd1 << G_LSB) - 64'd1);

  logic req_stex;
  assign req_stex = req_valid_i && (req_op_i == 3'd3);

  AST_LDEX_RECORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd2 && req_size_i == 2'd0)
    |=> (resv_vld && resv_tag == ($past(req_addr_i) & KEEP))); // R1

  AST_PERMIT_NEEDS_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_permit_o |-> (req_stex && resv_vld && resv_tag == (req_addr_i & KEEP))); // R3

  AST_STATUS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_stex |-> (st_permit_o ? status_o == 32'd0 : status_o == 32'd1)); // R4

  AST_IDLE_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_stex |-> (!st_permit_o && status_o == 32'd0)); // R4

  AST_STEX_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_stex |=> !resv_vld); // R5

  AST_CLREX_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd4) |=> !resv_vld); // R6

  AST_ERET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd5) |=> !resv_vld); // R7

  AST_PLAIN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_op_i <= 3'd1 || req_op_i >= 3'd6))
    |=> ($stable(resv_vld) && $stable(resv_tag))); // R10

  AST_IDLE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(resv_vld) && $stable(resv_tag))); // R12
endmodule

bind excl_monitor excl_monitor_chk #(.PA_W(PA_W), .G_LSB(G_LSB)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .st_permit_o (st_permit_o),
  .status_o    (status_o),
  .resv_vld    (resv_vld),
  .resv_tag    (resv_tag)
);

// File: tb/test_excl_monitor.sv
module test_excl_monitor;
  localparam int unsigned PA_W = 40;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic [2:0]      req_op_i = 3'd0;
  logic [PA_W-1:0] req_addr_i = '0;
  logic [1:0]      req_size_i = 2'd0;
  logic            st_permit_o;
  logic [31:0]     status_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  excl_monitor #(.PA_W(PA_W), .GRANULE_B(64)) i_excl_monitor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .st_permit_o (st_permit_o),
    .status_o    (status_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one request for one cycle; outputs sampled mid low phase.
  task automatic issue(input logic vld, input logic [2:0] op, input logic [PA_W-1:0] addr,
                       input logic [1:0] sz, output logic permit, output logic [31:0] stat);
    @(negedge clk_i);
    req_valid_i = vld;
    req_op_i    = op;
    req_addr_i  = addr;
    req_size_i  = sz;
    #2;
    permit = st_permit_o;
    stat   = status_o;
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0;
  endtask

  task automatic op_only(input logic [2:0] op, input logic [PA_W-1:0] addr, input logic [1:0] sz);
    logic p;
    logic [31:0] s;
    issue(1'b1, op, addr, sz, p, s);
  endtask

  task automatic stex_expect(string req, input logic [PA_W-1:0] addr, input logic [1:0] sz,
                             input logic pass);
    logic p;
    logic [31:0] s;
    issue(1'b1, 3'd3, addr, sz, p, s);
    check(req, {31'd0, p}, {31'd0, pass});
    check(req, s, pass ? 32'd0 : 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R4 idle permit", {31'd0, st_permit_o}, 32'd0);
    check("R4 idle status", status_o, 32'd0);
    stex_expect("R11 first stex after reset", 40'h1000, 2'd3, 1'b0);
  endtask

  task automatic t_basic;
    op_only(3'd2, 40'h1000, 2'd3);
    stex_expect("R1 R3 stex after ldex", 40'h1000, 2'd3, 1'b1);
    stex_expect("R5 second stex fails", 40'h1000, 2'd3, 1'b0);
    op_only(3'd2, 40'h2000, 2'd2);
    stex_expect("R5 mismatched stex fails", 40'h3000, 2'd2, 1'b0);
    stex_expect("R5 tag gone after failed stex", 40'h2000, 2'd2, 1'b0);
  endtask

  task automatic t_granule;
    op_only(3'd2, 40'h1000, 2'd0);
    stex_expect("R8 same granule other word", 40'h1038, 2'd3, 1'b1);
    op_only(3'd2, 40'h103F, 2'd0);
    stex_expect("R8 granule base", 40'h1000, 2'd2, 1'b1);
    op_only(3'd2, 40'h1000, 2'd3);
    stex_expect("R8 next granule", 40'h1040, 2'd3, 1'b0);
    op_only(3'd2, 40'h80_0000_1000, 2'd3);
    stex_expect("R8 high bit differs", 40'h1000, 2'd3, 1'b0);
  endtask

  task automatic t_replace;
    op_only(3'd2, 40'h4000, 2'd3);
    op_only(3'd2, 40'h5000, 2'd3);
    stex_expect("R2 old reservation lost", 40'h4000, 2'd3, 1'b0);
    op_only(3'd2, 40'h4000, 2'd3);
    op_only(3'd2, 40'h5000, 2'd3);
    stex_expect("R2 new reservation held", 40'h5000, 2'd3, 1'b1);
  endtask

  task automatic t_clear;
    logic p;
    logic [31:0] s;
    op_only(3'd2, 40'h6000, 2'd3);
    issue(1'b1, 3'd4, 40'h0, 2'd0, p, s);
    check("R4 clrex outputs idle", {31'd0, p} | s, 32'd0);
    stex_expect("R6 clrex clears", 40'h6000, 2'd3, 1'b0);
    op_only(3'd2, 40'h6000, 2'd3);
    op_only(3'd5, 40'h0, 2'd0);
    stex_expect("R7 eret clears", 40'h6000, 2'd3, 1'b0);
  endtask

  task automatic t_plain;
    logic p;
    logic [31:0] s;
    op_only(3'd2, 40'h7000, 2'd3);
    issue(1'b1, 3'd1, 40'h7000, 2'd3, p, s);
    check("R10 store gives no permit", {31'd0, p}, 32'd0);
    op_only(3'd0, 40'h7008, 2'd3);
    op_only(3'd6, 40'h9000, 2'd3);
    op_only(3'd7, 40'h9000, 2'd3);
    stex_expect("R10 plain traffic keeps tag", 40'h7000, 2'd3, 1'b1);
    op_only(3'd2, 40'h7000, 2'd3);
    issue(1'b0, 3'd3, 40'h7000, 2'd3, p, s);
    check("R12 invalid stex permit", {31'd0, p}, 32'd0);
    check("R12 invalid stex status", s, 32'd0);
    issue(1'b0, 3'd4, 40'h0, 2'd0, p, s);
    issue(1'b0, 3'd2, 40'h8000, 2'd3, p, s);
    stex_expect("R12 invalid requests ignored", 40'h7000, 2'd3, 1'b1);
  endtask

  task automatic t_align;
    op_only(3'd2, 40'hA000, 2'd3);
    stex_expect("R9 misaligned dword stex", 40'hA004, 2'd3, 1'b0);
    op_only(3'd2, 40'hA000, 2'd2);
    op_only(3'd2, 40'hA002, 2'd2);
    stex_expect("R9 misaligned ldex untags", 40'hA000, 2'd2, 1'b0);
    op_only(3'd2, 40'hB001, 2'd0);
    stex_expect("R9 byte any offset", 40'hB001, 2'd0, 1'b1);
    op_only(3'd2, 40'hB002, 2'd1);
    stex_expect("R9 aligned halfword", 40'hB002, 2'd1, 1'b1);
    op_only(3'd2, 40'hB002, 2'd1);
    stex_expect("R9 odd halfword", 40'hB003, 2'd1, 1'b0);
    op_only(3'd2, 40'hB004, 2'd2);
    stex_expect("R9 aligned word", 40'hB004, 2'd2, 1'b1);
  endtask

  initial begin
    #45 rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_granule();
    t_replace();
    t_clear();
    t_plain();
    t_align();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule